// File: doc/BRIEF.md
# Four-Plane Video Memory Data Path

This block is the data-side engine that sits between a host byte bus and a video memory organised as four parallel byte planes. On a host write it turns a single host byte into four plane bytes and four plane write enables. The write mode selects how the host byte, the per-plane fill colour, the saved latch contents and an 8-bit bit mask are merged. On a host read it returns either the byte of one chosen plane or a colour-match byte built from all four planes.

A 32-bit latch holds one byte per plane. Every completed host read reloads it from the plane read data. Write modes use it as the "old pixel" operand, which lets software move whole 4-plane units with a read followed by a write. Address translation and the storage itself live outside the block. The block sees only the plane read data bus and drives the plane write data bus and the enables.

Top module: `plane_data_path`

## Requirements
- R1: A synchronous active-low reset clears the latch to zero, so a write in mode 1 right after reset drives `plane_wdata` = 0.
- R2: Write mode 0 (`wr_mode`=0) rotates the host byte right by `rot_cnt`. For each plane i whose `en_set_rst[i]` is 1, the rotated byte is replaced by `set_rst[i]` repeated eight times.
- R3: In write modes 0 and 2, each plane byte is combined with that plane's latch byte by `logic_op`: 0 passes the byte unchanged, 1 = AND, 2 = OR, 3 = XOR.
- R4: In write modes 0 and 2, each result bit whose `bit_mask` bit is 1 takes the combined value, and each bit whose mask bit is 0 takes the latch bit.
- R5: Write mode 1 drives the full 32-bit latch onto `plane_wdata` and ignores the host byte, rotate count, fill colour, operation and mask.
- R6: Write mode 2 fills plane i with host bit i repeated eight times (i = 0..3) before the operation and mask of R3/R4.
- R7: Write mode 3 uses `set_rst[i]` repeated eight times as plane i's data, whatever `en_set_rst` holds. It selects bitwise between that data and the latch with the effective mask (host byte rotated right by `rot_cnt`) AND `bit_mask`. No logical operation is applied.
- R8: `plane_we[i]` equals `wr_stb` AND `map_mask[i]`, and it is valid in the same cycle as `wr_stb`. No enable is high while `wr_stb` is low.
- R9: With `rd_mode`=0, `host_rdata` equals the byte of plane `rd_plane_sel`. Plane i occupies bits [8i+7:8i] of both plane buses.
- R10: With `rd_mode`=1, bit b of `host_rdata` is 1 when every plane i with `cmp_care[i]`=1 has bit b equal to `cmp_color[i]`. If no plane is cared for, all bits are 1.
- R11: On the clock edge where `rd_stb` is high, the latch loads all of `plane_rdata` in both read modes. Without `rd_stb` the latch keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb | input | 1 | Host write in this cycle |
| rd_stb | input | 1 | Host read completes in this cycle |
| host_wdata | input | 8 | Host write byte |
| wr_mode | input | 2 | Write mode 0..3 |
| logic_op | input | 2 | 0 pass, 1 AND, 2 OR, 3 XOR |
| rot_cnt | input | 3 | Right-rotate count for host byte |
| set_rst | input | 4 | Per-plane fill colour bit |
| en_set_rst | input | 4 | Per-plane fill substitution enable (mode 0) |
| bit_mask | input | 8 | Bit select between new data and latch |
| map_mask | input | 4 | Per-plane write permission |
| rd_mode | input | 1 | 0 plane select, 1 colour match |
| rd_plane_sel | input | 2 | Plane returned in read mode 0 |
| cmp_color | input | 4 | Reference colour for match |
| cmp_care | input | 4 | Planes taking part in the match |
| plane_rdata | input | 32 | Read data of the four planes |
| plane_wdata | output | 32 | Write data of the four planes |
| plane_we | output | 4 | Per-plane write enable |
| host_rdata | output | 8 | Byte returned to host |

## Verification
The hardest state to reach from the ports is a latch that differs from the current plane read data in known ways. Every write result depends on it, but it can only be set through a completed read. The bench therefore loads several distinct latch patterns with read strobes, changes `plane_rdata` to unrelated values, and then sweeps every write mode, operation and rotate count against several fill and host patterns. Latch hold and zero-after-reset show up through mode 1 writes.

// File: rtl/plane_dp_pkg.sv
// Shared encodings for the four-plane data path.
// Assumes the mode fields arrive as plain 2-bit codes from control registers.
package plane_dp_pkg;
    typedef enum logic [1:0] {
        WM_SUBST  = 2'd0,
        WM_LATCH  = 2'd1,
        WM_SPREAD = 2'd2,
        WM_MASKED = 2'd3
    } wr_mode_e;

    typedef enum logic [1:0] {
        OP_PASS = 2'd0,
        OP_AND  = 2'd1,
        OP_OR   = 2'd2,
        OP_XOR  = 2'd3
    } alu_op_e;
endpackage

// File: rtl/plane_latch.sv
// Holds one byte per plane, captured from the plane read bus on a read strobe.
// Assumes rd_stb marks the cycle in which plane_rdata is valid.
module plane_latch #(
    parameter int PLANES = 4,
    parameter int BYTE_W = 8,
    localparam int BUS_W = PLANES * BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_stb,
    input  logic [BUS_W-1:0] plane_rdata,
    output logic [BUS_W-1:0] latch_q
);
    // Capture read data, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            latch_q <= '0;
        else if (rd_stb)
            latch_q <= plane_rdata;
    end

    // R11: a completed read shows up in the latch next cycle.
    a_r11_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> latch_q == $past(plane_rdata));

    // R11: without a read the latch does not move.
    a_r11_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(latch_q));
endmodule

// File: rtl/plane_write_unit.sv
// Combinational write-data generator, one slice per plane.
// Assumes the control fields are stable for the cycle in which they are used.
module plane_write_unit
    import plane_dp_pkg::*;
#(
    parameter int PLANES = 4,
    parameter int BYTE_W = 8,
    localparam int BUS_W = PLANES * BYTE_W,
    localparam int ROT_W = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] host_wdata,
    input  logic [1:0]        wr_mode,
    input  logic [1:0]        logic_op,
    input  logic [ROT_W-1:0]  rot_cnt,
    input  logic [PLANES-1:0] set_rst,
    input  logic [PLANES-1:0] en_set_rst,
    input  logic [BYTE_W-1:0] bit_mask,
    input  logic [BUS_W-1:0]  latch_q,
    output logic [BUS_W-1:0]  plane_wdata
);
    wr_mode_e mode;
    alu_op_e  op;
    logic [2*BYTE_W-1:0] rot_wide;
    logic [BYTE_W-1:0]   rotated;
    logic [BYTE_W-1:0]   eff_mask;

    assign mode = wr_mode_e'(wr_mode);
    assign op   = alu_op_e'(logic_op);

    // Rotate host byte right by shifting a doubled copy.
    always_comb begin
        rot_wide = {host_wdata, host_wdata} >> rot_cnt;
        rotated  = rot_wide[BYTE_W-1:0];
        eff_mask = rotated & bit_mask;
    end

    for (genvar p = 0; p < PLANES; p++) begin : g_plane
        logic [BYTE_W-1:0] old_b;
        logic [BYTE_W-1:0] fill_b;
        logic [BYTE_W-1:0] src_b;
        logic [BYTE_W-1:0] alu_b;
        logic [BYTE_W-1:0] out_b;

        assign old_b  = latch_q[p*BYTE_W +: BYTE_W];
        assign fill_b = {BYTE_W{set_rst[p]}};

        // Pick the source byte for modes 0 and 2.
        always_comb begin
            if (mode == WM_SPREAD)
                src_b = {BYTE_W{host_wdata[p]}};
            else if (en_set_rst[p])
                src_b = fill_b;
            else
                src_b = rotated;
        end

        // Combine source with latch byte.
        always_comb begin
            case (op)
                OP_AND:  alu_b = src_b & old_b;
                OP_OR:   alu_b = src_b | old_b;
                OP_XOR:  alu_b = src_b ^ old_b;
                default: alu_b = src_b;
            endcase
        end

        // Final per-mode selection of the plane byte.
        always_comb begin
            case (mode)
                WM_LATCH:  out_b = old_b;
                WM_MASKED: out_b = (fill_b & eff_mask) | (old_b & ~eff_mask);
                default:   out_b = (alu_b & bit_mask) | (old_b & ~bit_mask);
            endcase
        end

        assign plane_wdata[p*BYTE_W +: BYTE_W] = out_b;
    end

    // R5: mode 1 copies the latch regardless of other inputs.
    a_r5_latch_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mode == 2'd1) |-> plane_wdata == latch_q);

    // R7: in mode 3 a zero bit mask leaves every plane at the latch value.
    a_r7_zero_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mode == 2'd3 && bit_mask == '0) |-> plane_wdata == latch_q);

    // R4: in modes 0 and 2 a zero bit mask also keeps the latch.
    a_r4_mask_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_mode[0] && bit_mask == '0) |-> plane_wdata == latch_q);
endmodule

// File: rtl/plane_read_unit.sv
// Forms the host read byte: one plane, or a per-bit colour match.
// Assumes plane_rdata is the live read data of the four planes.
module plane_read_unit #(
    parameter int PLANES = 4,
    parameter int BYTE_W = 8,
    localparam int BUS_W = PLANES * BYTE_W,
    localparam int SEL_W = $clog2(PLANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_mode,
    input  logic [SEL_W-1:0]  rd_plane_sel,
    input  logic [PLANES-1:0] cmp_color,
    input  logic [PLANES-1:0] cmp_care,
    input  logic [BUS_W-1:0]  plane_rdata,
    output logic [BYTE_W-1:0] host_rdata
);
    logic [BYTE_W-1:0] sel_b;
    logic [BYTE_W-1:0] match_b;

    // Select one plane byte.
    assign sel_b = plane_rdata[rd_plane_sel*BYTE_W +: BYTE_W];

    for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
        logic [PLANES-1:0] diff;
        for (genvar p = 0; p < PLANES; p++) begin : g_pl
            assign diff[p] = cmp_care[p] & (plane_rdata[p*BYTE_W + b] ^ cmp_color[p]);
        end
        assign match_b[b] = ~|diff;
    end

    // Choose between selected plane and match result.
    assign host_rdata = rd_mode ? match_b : sel_b;

    // R10: with no cared planes every bit reports a match.
    a_r10_all_dont_care: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_mode && cmp_care == '0) |-> host_rdata == '1);

    // R9: plane-select mode returns plane 0 when selector is zero.
    a_r9_plane0: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_mode && rd_plane_sel == '0) |-> host_rdata == plane_rdata[BYTE_W-1:0]);
endmodule

// File: rtl/plane_data_path.sv
// Top of the four-plane data path: latch, write generator, read former.
// Assumes at most one of wr_stb and rd_stb per cycle is meaningful to memory;
// the block itself does not arbitrate them.
module plane_data_path #(
    parameter int PLANES = 4,
    parameter int BYTE_W = 8,
    localparam int BUS_W = PLANES * BYTE_W,
    localparam int ROT_W = $clog2(BYTE_W),
    localparam int SEL_W = $clog2(PLANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic [BYTE_W-1:0] host_wdata,
    input  logic [1:0]        wr_mode,
    input  logic [1:0]        logic_op,
    input  logic [ROT_W-1:0]  rot_cnt,
    input  logic [PLANES-1:0] set_rst,
    input  logic [PLANES-1:0] en_set_rst,
    input  logic [BYTE_W-1:0] bit_mask,
    input  logic [PLANES-1:0] map_mask,
    input  logic              rd_mode,
    input  logic [SEL_W-1:0]  rd_plane_sel,
    input  logic [PLANES-1:0] cmp_color,
    input  logic [PLANES-1:0] cmp_care,
    input  logic [BUS_W-1:0]  plane_rdata,
    output logic [BUS_W-1:0]  plane_wdata,
    output logic [PLANES-1:0] plane_we,
    output logic [BYTE_W-1:0] host_rdata
);
    logic [BUS_W-1:0] latch_q;

    plane_latch #(.PLANES(PLANES), .BYTE_W(BYTE_W)) u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_stb      (rd_stb),
        .plane_rdata (plane_rdata),
        .latch_q     (latch_q)
    );

    plane_write_unit #(.PLANES(PLANES), .BYTE_W(BYTE_W)) u_write (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_wdata  (host_wdata),
        .wr_mode     (wr_mode),
        .logic_op    (logic_op),
        .rot_cnt     (rot_cnt),
        .set_rst     (set_rst),
        .en_set_rst  (en_set_rst),
        .bit_mask    (bit_mask),
        .latch_q     (latch_q),
        .plane_wdata (plane_wdata)
    );

    plane_read_unit #(.PLANES(PLANES), .BYTE_W(BYTE_W)) u_read (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_mode      (rd_mode),
        .rd_plane_sel (rd_plane_sel),
        .cmp_color    (cmp_color),
        .cmp_care     (cmp_care),
        .plane_rdata  (plane_rdata),
        .host_rdata   (host_rdata)
    );

    // Gate per-plane permission with the write strobe.
    assign plane_we = map_mask & {PLANES{wr_stb}};

    // R8: no plane is enabled without a write strobe.
    a_r8_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |-> plane_we == '0);

    // R8: enables never exceed the plane permissions.
    a_r8_within_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (plane_we & ~map_mask) == '0);
endmodule

// File: tb/plane_data_path_bench.sv
// Sweep bench for plane_data_path with arithmetic reference models.
module plane_data_path_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic        rd_stb = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [1:0]  wr_mode = '0;
    logic [1:0]  logic_op = '0;
    logic [2:0]  rot_cnt = '0;
    logic [3:0]  set_rst = '0;
    logic [3:0]  en_set_rst = '0;
    logic [7:0]  bit_mask = '0;
    logic [3:0]  map_mask = '0;
    logic        rd_mode = 1'b0;
    logic [1:0]  rd_plane_sel = '0;
    logic [3:0]  cmp_color = '0;
    logic [3:0]  cmp_care = '0;
    logic [31:0] plane_rdata = '0;
    logic [31:0] plane_wdata;
    logic [3:0]  plane_we;
    logic [7:0]  host_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    plane_data_path u_plane_data_path (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .host_wdata(host_wdata), .wr_mode(wr_mode), .logic_op(logic_op),
        .rot_cnt(rot_cnt), .set_rst(set_rst), .en_set_rst(en_set_rst),
        .bit_mask(bit_mask), .map_mask(map_mask), .rd_mode(rd_mode),
        .rd_plane_sel(rd_plane_sel), .cmp_color(cmp_color), .cmp_care(cmp_care),
        .plane_rdata(plane_rdata), .plane_wdata(plane_wdata),
        .plane_we(plane_we), .host_rdata(host_rdata)
    );

    function automatic logic [7:0] ror8(input logic [7:0] x, input int n);
        return 8'((x >> n) | (x << (8 - n)));
    endfunction

    // Reference write model from R2..R7.
    function automatic logic [31:0] ref_write(input int m, input int op, input int rot,
                                              input logic [7:0] h, input logic [3:0] sr,
                                              input logic [3:0] esr, input logic [7:0] bm,
                                              input logic [31:0] lat);
        logic [31:0] r;
        for (int p = 0; p < 4; p++) begin
            logic [7:0] l, s, a, o, em, f;
            l = lat[p*8 +: 8];
            f = sr[p] ? 8'hFF : 8'h00;
            if (m == 2) s = h[p] ? 8'hFF : 8'h00;
            else s = esr[p] ? f : ror8(h, rot);
            case (op)
                1: a = s & l;
                2: a = s | l;
                3: a = s ^ l;
                default: a = s;
            endcase
            em = ror8(h, rot) & bm;
            case (m)
                1: o = l;
                3: o = (f & em) | (l & ~em);
                default: o = (a & bm) | (l & ~bm);
            endcase
            r[p*8 +: 8] = o;
        end
        return r;
    endfunction

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load_latch(input logic [31:0] v);
        @(negedge clk);
        plane_rdata = v;
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    initial begin
        logic [31:0] lat_set [3];
        logic [7:0]  host_set [4];
        logic [3:0]  nib_set [4];
        logic [31:0] rd_set [4];
        lat_set  = '{32'hA5_3C_F0_0F, 32'h00_FF_55_AA, 32'h12_34_56_78};
        host_set = '{8'h81, 8'h5A, 8'hF3, 8'h06};
        nib_set  = '{4'h0, 4'hF, 4'h5, 4'hC};
        rd_set   = '{32'h00000000, 32'hFF00FF00, 32'h0F33_55AA, 32'hC3_69_96_3C};

        repeat (3) @(negedge clk);
        plane_rdata = 32'hDEADBEEF;
        rst_n = 1'b1;
        #1;
        // R1: latch clear after reset, seen via mode 1
        wr_mode = 2'd1; host_wdata = 8'hFF;
        #1 check32("R1 reset latch", plane_wdata, 32'h0);

        // Write sweep across latch patterns
        foreach (lat_set[li]) begin
            load_latch(lat_set[li]);
            plane_rdata = ~lat_set[li];
            #1;
            for (int m = 0; m < 4; m++)
            for (int op = 0; op < 4; op++)
            for (int rot = 0; rot < 8; rot++)
            foreach (host_set[hi])
            foreach (nib_set[ei])
            foreach (nib_set[si]) begin
                logic [7:0] bm;
                bm = 8'((rot * 37 + hi * 91 + si * 17) ^ 8'h3C);
                if (hi == 0) bm = 8'h00;
                wr_mode = 2'(m); logic_op = 2'(op); rot_cnt = 3'(rot);
                host_wdata = host_set[hi]; en_set_rst = nib_set[ei];
                set_rst = nib_set[si]; bit_mask = bm;
                map_mask = 4'(rot + op); wr_stb = (rot % 3) != 0;
                #1;
                case (m)
                    0: check32("R2,R3,R4 mode0", plane_wdata,
                               ref_write(m, op, rot, host_wdata, set_rst, en_set_rst, bm, lat_set[li]));
                    1: check32("R5 mode1", plane_wdata, lat_set[li]);
                    2: check32("R6,R3,R4 mode2", plane_wdata,
                               ref_write(m, op, rot, host_wdata, set_rst, en_set_rst, bm, lat_set[li]));
                    default: check32("R7 mode3", plane_wdata,
                               ref_write(m, op, rot, host_wdata, set_rst, en_set_rst, bm, lat_set[li]));
                endcase
                check32("R8 enables", {28'h0, plane_we}, {28'h0, wr_stb ? map_mask : 4'h0});
            end
        end
        wr_stb = 1'b0;

        // R11: hold without strobe, then load in colour-match read mode
        plane_rdata = 32'h11223344;
        repeat (2) @(negedge clk);
        wr_mode = 2'd1;
        #1 check32("R11 hold", plane_wdata, lat_set[2]);
        rd_mode = 1'b1;
        load_latch(32'hCAFE0123);
        plane_rdata = 32'h0;
        #1 check32("R11 load in match mode", plane_wdata, 32'hCAFE0123);

        // Read sweep
        foreach (rd_set[di]) begin
            plane_rdata = rd_set[di];
            rd_mode = 1'b0;
            for (int s = 0; s < 4; s++) begin
                rd_plane_sel = 2'(s);
                #1 check32("R9 plane select", {24'h0, host_rdata}, {24'h0, rd_set[di][s*8 +: 8]});
            end
            rd_mode = 1'b1;
            for (int c = 0; c < 16; c++)
            for (int k = 0; k < 16; k++) begin
                logic [7:0] e;
                cmp_color = 4'(c); cmp_care = 4'(k);
                for (int b = 0; b < 8; b++) begin
                    e[b] = 1'b1;
                    for (int p = 0; p < 4; p++)
                        if (cmp_care[p] && (rd_set[di][p*8 + b] != cmp_color[p])) e[b] = 1'b0;
                end
                #1 check32("R10 colour match", {24'h0, host_rdata}, {24'h0, e});
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hang counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule